// File: doc/BRIEF.md
# Quad Byte-Lane SIMD ALU

This unit treats each 32-bit operand as four unsigned byte lanes and applies one of four operations to all lanes at once: wrapping addition, wrapping subtraction, rounded averaging, and an absolute-difference step that also adds each lane's difference into its own running total. It is intended for pixel work such as motion-estimation cost sums, where one pass over a block of pixels adds up the absolute differences for each lane.

An operation is issued by raising `op_valid` with the opcode and operands for one clock. The packed result is registered and appears on the next clock, with `result_valid` high for exactly that cycle. Four 16-bit accumulators, one per lane, collect the absolute differences. A clear input starts a new accumulation.

Top module: `quad_byte_alu`

## Requirements
- R1: While `rst_n` is low and after it is released, `result`, `result_valid` and all four accumulators read zero until an operation or accumulation changes them.
- R2: Lane i occupies bits 8i+7:8i of `opnd_a`, `opnd_b` and `result`, and accumulator i occupies bits 16i+15:16i of `acc_out`. Opcode 2'b00 is add, 2'b01 is subtract, 2'b10 is average and 2'b11 is absolute-difference accumulate. `result` updates on the clock edge that samples `op_valid` high, and `result_valid` is high during the following cycle only.
- R3: Add gives (a+b) mod 256 in every lane, and no carry passes from one lane to the next.
- R4: Subtract gives (a-b) mod 256 in every lane, and no borrow passes from one lane to the next.
- R5: Average gives (a+b+1)>>1 in every lane, computed without overflow (255 and 255 give 255).
- R6: Absolute-difference accumulate puts |a-b| in each result lane and adds it to that lane's accumulator.
- R7: An accumulator that would pass 65535 holds at 65535.
- R8: `acc_clear` high with no accumulate op sets all accumulators to zero. When it is high together with an accumulate op, each accumulator loads that op's |a-b|.
- R9: When no accumulate op is issued and `acc_clear` is low, the accumulators do not change. When `op_valid` is low, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 2 | Operation select (see R2) |
| opnd_a | input | 32 | Packed first operand, four bytes |
| opnd_b | input | 32 | Packed second operand, four bytes |
| acc_clear | input | 1 | Restart the per-lane accumulators |
| result | output | 32 | Packed lane results, registered |
| result_valid | output | 1 | High the cycle after an issued operation |
| acc_out | output | 64 | Four 16-bit per-lane accumulators |

## Verification
The properties assume that `op_valid`, `op_code` and `acc_clear` are always 0 or 1, never unknown, and that they change only between clock edges. The stimulus drives every input on the falling edge, always with defined values. It holds the opcode and operands fixed while an operation is sampled and lowers `op_valid` on idle cycles, so the hold properties can be observed. The monotonic accumulator property assumes the accumulators start from the reset value of zero, and the reset sequence provides that before any accumulation.

// File: rtl/qb_pkg.sv
// Package qb_pkg: shared opcode type and default geometry for the
// quad byte-lane ALU. Assumes opcodes are two bits wide.
package qb_pkg;
    typedef enum logic [1:0] {
        QB_ADD = 2'b00,
        QB_SUB = 2'b01,
        QB_AVG = 2'b10,
        QB_SAD = 2'b11
    } qb_op_e;
endpackage

// File: rtl/qb_lane.sv
// Module qb_lane: purely combinational arithmetic for one unsigned lane.
// Produces the lane result for the selected opcode and the absolute
// difference used by the accumulator. Assumes unsigned operands.
module qb_lane
    import qb_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  qb_op_e             op,
    input  logic [LANE_W-1:0]  a,
    input  logic [LANE_W-1:0]  b,
    output logic [LANE_W-1:0]  res,
    output logic [LANE_W-1:0]  absdiff
);
    logic [LANE_W:0] wide_sum;
    logic [LANE_W:0] rounded;

    // Widened sum and rounding term for the average
    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b};
        rounded  = wide_sum + {{LANE_W{1'b0}}, 1'b1};
    end

    // Absolute difference, subtracting the smaller operand
    always_comb begin
        if (a >= b) absdiff = a - b;
        else        absdiff = b - a;
    end

    // Opcode selection of the lane result
    always_comb begin
        unique case (op)
            QB_ADD:  res = wide_sum[LANE_W-1:0];
            QB_SUB:  res = a - b;
            QB_AVG:  res = rounded[LANE_W:1];
            default: res = absdiff;
        endcase
    end
endmodule

// File: rtl/qb_acc.sv
// Module qb_acc: one saturating unsigned accumulator for a lane.
// A clear together with an accumulate starts from zero, and a clear
// alone zeroes the total. Assumes ACC_W > LANE_W.
module qb_acc #(
    parameter int LANE_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [LANE_W-1:0] diff,
    output logic [ACC_W-1:0]  acc
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   total;
    logic [ACC_W-1:0] next_acc;

    // Pick the starting value and add with one extra carry bit
    always_comb begin
        base  = clr ? '0 : acc;
        total = {1'b0, base} + {{(ACC_W+1-LANE_W){1'b0}}, diff};
        next_acc = total[ACC_W] ? ACC_MAX : total[ACC_W-1:0];
    end

    // Register the accumulator
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (acc_en) acc <= next_acc;
        else if (clr)    acc <= '0;
    end
endmodule

// File: rtl/quad_byte_alu.sv
// Module quad_byte_alu: top of the packed-byte SIMD ALU. Replicates
// the lane datapath and accumulator per lane, registers the packed
// result, and flags it valid for one cycle. Assumes lane 0 sits in the
// least significant bits and that all lanes are unsigned.
module quad_byte_alu
    import qb_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int ACC_W  = 16,
    localparam int DATA_W = LANES * LANE_W,
    localparam int ACCS_W = LANES * ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              acc_clear,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic [ACCS_W-1:0] acc_out
);
    qb_op_e            op;
    logic              do_sad;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] lane_diff;

    // Decode the opcode and the accumulate strobe
    always_comb begin
        op     = qb_op_e'(op_code);
        do_sad = op_valid && (op == QB_SAD);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        qb_lane #(.LANE_W(LANE_W)) u_lane (
            .op      (op),
            .a       (opnd_a[i*LANE_W +: LANE_W]),
            .b       (opnd_b[i*LANE_W +: LANE_W]),
            .res     (lane_res[i*LANE_W +: LANE_W]),
            .absdiff (lane_diff[i*LANE_W +: LANE_W])
        );

        qb_acc #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (acc_clear),
            .acc_en (do_sad),
            .diff   (lane_diff[i*LANE_W +: LANE_W]),
            .acc    (acc_out[i*ACC_W +: ACC_W])
        );
    end

    // Register the packed result when an operation is issued
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (op_valid) result <= lane_res;
    end

    // One-cycle valid flag following each issued operation
    always_ff @(posedge clk) begin
        if (!rst_n) result_valid <= 1'b0;
        else        result_valid <= op_valid;
    end
endmodule

// File: rtl/qb_checker.sv
// Module qb_checker: temporal properties of quad_byte_alu, bound to it.
// Assumes control inputs are never unknown.
module qb_checker #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int ACC_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      op_valid,
    input logic [1:0]                op_code,
    input logic [LANES*LANE_W-1:0]   opnd_a,
    input logic [LANES*LANE_W-1:0]   opnd_b,
    input logic                      acc_clear,
    input logic [LANES*LANE_W-1:0]   result,
    input logic                      result_valid,
    input logic [LANES*ACC_W-1:0]    acc_out
);
    logic sad_issue;
    assign sad_issue = op_valid && (op_code == 2'b11);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> result_valid);

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !result_valid);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));

    a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clear && !sad_issue) |=> $stable(acc_out));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clear && !sad_issue) |=> (acc_out == '0));

    a_r3_lane0_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'b00) |=>
        (result[LANE_W-1:0] == LANE_W'($past(opnd_a[LANE_W-1:0]) + $past(opnd_b[LANE_W-1:0]))));

    for (genvar i = 0; i < LANES; i++) begin : g_mono
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (sad_issue && !acc_clear) |=>
            (acc_out[i*ACC_W +: ACC_W] >= $past(acc_out[i*ACC_W +: ACC_W])));
    end
endmodule

bind quad_byte_alu qb_checker #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .acc_clear    (acc_clear),
    .result       (result),
    .result_valid (result_valid),
    .acc_out      (acc_out)
);

// File: tb/sim_quad_byte_alu.sv
// Bench for quad_byte_alu: behavioural reference model updated on each
// rising edge, compared against the outputs on each falling edge.
module sim_quad_byte_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        acc_clear = 1'b0;
    logic [31:0] result;
    logic        result_valid;
    logic [63:0] acc_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference state
    logic [31:0] m_res = '0;
    bit          m_vld = 1'b0;
    int          m_acc [4] = '{0, 0, 0, 0};

    quad_byte_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_clear(acc_clear),
        .result(result), .result_valid(result_valid), .acc_out(acc_out)
    );

    always #5 clk = ~clk;

    // Advance the reference model by one clock, using the driven inputs
    task automatic model_tick();
        int a, b, r, d;
        logic [31:0] nr;
        if (!rst_n) begin
            m_res = '0; m_vld = 0;
            for (int i = 0; i < 4; i++) m_acc[i] = 0;
            return;
        end
        nr = '0;
        for (int i = 0; i < 4; i++) begin
            a = int'(opnd_a[8*i +: 8]);
            b = int'(opnd_b[8*i +: 8]);
            d = (a > b) ? a - b : b - a;
            case (op_code)
                2'b00: r = (a + b) % 256;
                2'b01: r = (a - b + 256) % 256;
                2'b10: r = (a + b + 1) / 2;
                default: r = d;
            endcase
            nr[8*i +: 8] = 8'(r);
            if (op_valid && op_code == 2'b11) begin
                m_acc[i] = (acc_clear ? 0 : m_acc[i]) + d;
                if (m_acc[i] > 65535) m_acc[i] = 65535;
            end else if (acc_clear) begin
                m_acc[i] = 0;
            end
        end
        if (op_valid) m_res = nr;
        m_vld = op_valid;
    endtask

    // Compare all outputs against the model
    task automatic compare(input string tag);
        logic [63:0] ea;
        for (int i = 0; i < 4; i++) ea[16*i +: 16] = 16'(m_acc[i]);
        vectors++;
        if (result !== m_res || result_valid !== m_vld || acc_out !== ea) begin
            errors++;
            $display("FAIL %s: result=%h valid=%b acc=%h expected result=%h valid=%b acc=%h",
                     tag, result, result_valid, acc_out, m_res, m_vld, ea);
        end
    endtask

    // Drive one cycle, clock it, then check at the falling edge
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input bit clr, input string tag);
        op_valid = v; op_code = op; opnd_a = a; opnd_b = b; acc_clear = clr;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        step(1, 2'b00, 32'hFFFF_FFFF, 32'h0101_0101, 1'b0, "R1 in reset");
        step(1, 2'b11, 32'hFF00_FF00, 32'h00FF_00FF, 1'b0, "R1 in reset sad");
        rst_n = 1'b1;
        step(0, 2'b00, '0, '0, 1'b0, "R1 after reset");
        // R2/R3: lane layout, add wrap with no cross-lane carry
        step(1, 2'b00, 32'h01FF_80FF, 32'h0101_8001, 1'b0, "R3 add wrap");
        step(0, 2'b00, '0, '0, 1'b0, "R2 valid one cycle");
        step(1, 2'b00, 32'h0403_0201, 32'h1020_3040, 1'b0, "R2 lane order");
        // R4: subtract with borrow contained per lane
        step(1, 2'b01, 32'h0000_0100, 32'h0100_0001, 1'b0, "R4 sub wrap");
        step(1, 2'b01, 32'h80FF_7F10, 32'h7F00_8010, 1'b0, "R4 sub mix");
        // R5: average rounding and no overflow
        step(1, 2'b10, 32'hFF00_01FE, 32'hFF01_00FF, 1'b0, "R5 avg edges");
        // R9: idle holds result, non-SAD ops keep accumulators
        step(0, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R9 idle hold");
        // R6: accumulate absolute differences
        step(1, 2'b11, 32'h0A00_FF05, 32'h000A_0009, 1'b0, "R6 sad 1");
        step(1, 2'b11, 32'h0102_0304, 32'h0403_0201, 1'b0, "R6 sad 2");
        step(1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 add keeps acc");
        step(0, 2'b11, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, "R9 idle sad keeps acc");
        // R8: clear with and without accumulate
        step(1, 2'b11, 32'h0505_0505, 32'h0000_0A00, 1'b1, "R8 clear+sad");
        step(1, 2'b01, 32'h0505_0505, 32'h0000_0A00, 1'b1, "R8 clear with sub");
        step(0, 2'b00, '0, '0, 1'b1, "R8 clear idle");
        // R7: saturation after 260 maximal differences
        for (int k = 0; k < 260; k++)
            step(1, 2'b11, 32'hFF00_FF00, 32'h00FF_00FF, 1'b0, "R7 saturate");
        step(0, 2'b00, '0, '0, 1'b0, "R7 held at max");
        step(1, 2'b11, 32'h0000_0000, 32'h0000_0000, 1'b0, "R7 zero diff at max");
        // Mixed stimulus across all requirements
        for (int k = 0; k < 400; k++)
            step(1'($urandom_range(0, 3) != 0), 2'($urandom), $urandom, $urandom,
                 1'($urandom_range(0, 15) == 0), "R2 R3 R4 R5 R6 R8 R9 mixed");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expected=finish actual=timeout");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule